// File: doc/BRIEF.md
# Prioritized Bus Master Arbiter

This block decides which master owns a shared system bus. Four kinds of master compete: the processor core (with an ordinary request and a locked request for indivisible sequences), a DMA engine, a memory refresh controller (with a background request and an urgent request once too many refreshes are owed), and an external master that asks for the bus with a hold request and may drive it only while the block returns a hold acknowledge.

Internal masters keep the bus until the bus cycle they are running ends, which the bus sequencer signals with a one-clock end-of-cycle pulse. An internal owner that drops its request leaves the bus idle, and the block re-arbitrates at once. When the external master holds the bus and a DMA, urgent refresh or locked processor request arrives, the block withdraws the acknowledge. It then grants nobody until the external master drops its hold request. When nobody asks, the bus parks with the processor.

Top module: `bus_owner_arbiter`

## Requirements
- R1: While rst_n is low and at the first edge after it, grant is 4'b0001 (processor) and ext_hold_ack is 0.
- R2: grant uses bit 0 for the processor, bit 1 for DMA, bit 2 for refresh and bit 3 for the external master, and never has more than one bit set.
- R3: While an internal master holds the grant and still asserts its request, the grant does not change until a clock edge at which bus_cycle_end is 1.
- R4: At a re-arbitration edge (bus_cycle_end high, or the current internal owner not requesting), the grant changes, one edge later, to the highest active request in this order: locked processor, urgent refresh, DMA, external hold, processor, background refresh.
- R5: A locked processor request wins a re-arbitration even over urgent refresh, DMA and the external hold request at the same time.
- R6: Background refresh is granted only when no other request is active at the re-arbitration edge.
- R7: When the external hold request wins a re-arbitration, ext_hold_ack and grant bit 3 rise together at the next edge.
- R8: While ext_hold_ack is 1 and ext_hold_req stays 1, a locked processor, urgent refresh or DMA request clears ext_hold_ack and grant bit 3 at the next edge.
- R9: After a reclaim, grant stays all zero while ext_hold_req is 1. The edge that sees ext_hold_req low grants the highest internal request, or the processor if there is none.
- R10: If the external master drops ext_hold_req while acknowledged, the next edge clears ext_hold_ack and grants the highest internal request, or the processor if there is none.
- R11: With no request active at a re-arbitration edge, the grant goes to the processor.
- R12: While the external master is acknowledged, bus_cycle_end and the processor and background refresh requests do not change grant or ext_hold_ack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_lock_req | input | 1 | Processor request for a locked sequence |
| cpu_req | input | 1 | Ordinary processor request |
| dma_req | input | 1 | DMA engine request |
| rfsh_urgent_req | input | 1 | Refresh request once the owed count is high |
| rfsh_bg_req | input | 1 | Background refresh request |
| bus_cycle_end | input | 1 | One-clock pulse at the last clock of the running bus cycle |
| ext_hold_req | input | 1 | External master hold request |
| ext_hold_ack | output | 1 | Registered hold acknowledge; the external master may drive the bus while it is 1 |
| grant | output | 4 | One-hot registered grant (bit 0 processor, 1 DMA, 2 refresh, 3 external) |

## Verification
The properties take for granted that bus_cycle_end marks the end of a cycle run by the current internal owner, and that the external master answers a withdrawn acknowledge by eventually dropping its hold request. The block still behaves as defined if these do not hold, so no property depends on them for safety. The random stimulus keeps to them anyway. It pulses bus_cycle_end freely, raises the hold request in bursts, and releases it soon after the acknowledge falls, so that the reclaim and bus-wait paths recur often. Directed sequences then test each priority pairing and both ways of leaving the external hold.

// File: rtl/arb_pkg.sv
// Package: shared types and mapping helpers for the bus owner arbiter.
// Assumes priority level 0 is the most important request.
package arb_pkg;

    localparam int N_LEVELS   = 6;   // number of priority levels
    localparam int N_OWNERS   = 4;   // number of grant lines
    localparam int LVL_LOCK   = 0;   // locked processor
    localparam int LVL_URGENT = 1;   // urgent refresh
    localparam int LVL_DMA    = 2;   // DMA engine
    localparam int LVL_HOLD   = 3;   // external hold request
    localparam int LVL_CPU    = 4;   // ordinary processor
    localparam int LVL_BG     = 5;   // background refresh

    typedef enum logic [1:0] {
        OWN_CPU  = 2'd0,
        OWN_DMA  = 2'd1,
        OWN_RFSH = 2'd2,
        OWN_EXT  = 2'd3
    } owner_e;

    typedef enum logic [1:0] {
        ST_INT  = 2'd0,   // an internal master owns the bus
        ST_HOLD = 2'd1,   // external master acknowledged
        ST_WAIT = 2'd2    // acknowledge withdrawn, waiting for hold release
    } arb_state_e;

    // Which master a priority level belongs to.
    function automatic owner_e level_owner(input int lvl);
        case (lvl)
            LVL_LOCK, LVL_CPU:  return OWN_CPU;
            LVL_URGENT, LVL_BG: return OWN_RFSH;
            LVL_DMA:            return OWN_DMA;
            default:            return OWN_EXT;
        endcase
    endfunction

    // One-hot grant vector for an owner.
    function automatic logic [N_OWNERS-1:0] owner_onehot(input owner_e o);
        return N_OWNERS'(1) << o;
    endfunction

endpackage

// File: rtl/arb_req_map.sv
// Module: arb_req_map
// Folds the raw request pins into a priority-ordered level vector, a
// per-owner "still requesting" vector and the reclaim condition.
// Assumes all inputs are synchronous to the arbiter clock.
module arb_req_map
    import arb_pkg::*;
(
    input  logic                cpu_lock_req,
    input  logic                cpu_req,
    input  logic                dma_req,
    input  logic                rfsh_urgent_req,
    input  logic                rfsh_bg_req,
    input  logic                ext_hold_req,
    output logic [N_LEVELS-1:0] lvl_req,
    output logic [N_OWNERS-1:0] owner_req,
    output logic                reclaim_req
);

    // Place each request at its priority level.
    always_comb begin
        lvl_req             = '0;
        lvl_req[LVL_LOCK]   = cpu_lock_req;
        lvl_req[LVL_URGENT] = rfsh_urgent_req;
        lvl_req[LVL_DMA]    = dma_req;
        lvl_req[LVL_HOLD]   = ext_hold_req;
        lvl_req[LVL_CPU]    = cpu_req;
        lvl_req[LVL_BG]     = rfsh_bg_req;
    end

    // Gather every level of one owner into that owner's busy bit.
    always_comb begin
        owner_req = '0;
        for (int i = 0; i < N_LEVELS; i++) begin
            if (lvl_req[i]) owner_req[level_owner(i)] = 1'b1;
        end
    end

    // Any request ranked above the external hold takes the bus back.
    always_comb begin
        reclaim_req = 1'b0;
        for (int i = 0; i < LVL_HOLD; i++) begin
            reclaim_req = reclaim_req | lvl_req[i];
        end
    end

endmodule

// File: rtl/arb_prio_pick.sv
// Module: arb_prio_pick
// Fixed-priority selector: returns the owner of the lowest-numbered active
// level. Parks on the processor when no level is active. With INCLUDE_HOLD
// cleared the external hold level is masked, giving an internal-only pick.
module arb_prio_pick
    import arb_pkg::*;
#(
    parameter int LEVELS       = N_LEVELS,
    parameter bit INCLUDE_HOLD = 1'b1
) (
    input  logic [LEVELS-1:0] lvl_req,
    output owner_e            pick,
    output logic              any_req
);

    logic [LEVELS-1:0] req_m;

    // Select which levels take part in this pick.
    generate
        if (INCLUDE_HOLD) begin : g_all
            assign req_m = lvl_req;
        end else begin : g_int
            localparam logic [LEVELS-1:0] HOLD_MASK = ~(LEVELS'(1) << LVL_HOLD);
            assign req_m = lvl_req & HOLD_MASK;
        end
    endgenerate

    // Scan from lowest to highest priority so the highest one wins.
    always_comb begin
        pick = OWN_CPU;
        for (int i = LEVELS - 1; i >= 0; i--) begin
            if (req_m[i]) pick = level_owner(i);
        end
    end

    assign any_req = |req_m;

endmodule

// File: rtl/arb_owner_fsm.sv
// Module: arb_owner_fsm
// Holds the current owner and the hold handshake state. Internal owners
// are replaced only at a cycle end or when they stop requesting. The
// external owner is reclaimed by dropping the acknowledge, then waited
// out until its hold request falls. Grant and acknowledge are registered.
module arb_owner_fsm
    import arb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  owner_e              pick_all,
    input  owner_e              pick_int,
    input  logic [N_OWNERS-1:0] owner_req,
    input  logic                reclaim_req,
    input  logic                ext_hold_req,
    input  logic                bus_cycle_end,
    output logic [N_OWNERS-1:0] grant_q,
    output logic                hold_ack_q
);

    arb_state_e          state_q, state_n;
    owner_e              owner_q, owner_n;
    logic                owner_busy;
    logic [N_OWNERS-1:0] grant_n;
    logic                hold_ack_n;

    // Is the present internal owner still asking for cycles.
    assign owner_busy = owner_req[owner_q];

    // Next owner and handshake state.
    always_comb begin
        state_n = state_q;
        owner_n = owner_q;
        case (state_q)
            ST_INT: begin
                if (bus_cycle_end || !owner_busy) begin
                    owner_n = pick_all;
                    state_n = (pick_all == OWN_EXT) ? ST_HOLD : ST_INT;
                end
            end
            ST_HOLD: begin
                if (!ext_hold_req) begin
                    owner_n = pick_int;
                    state_n = ST_INT;
                end else if (reclaim_req) begin
                    state_n = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!ext_hold_req) begin
                    owner_n = pick_int;
                    state_n = ST_INT;
                end
            end
            default: begin
                owner_n = OWN_CPU;
                state_n = ST_INT;
            end
        endcase
    end

    // Output values for the next state; nobody is granted during the wait.
    always_comb begin
        grant_n    = (state_n == ST_WAIT) ? '0 : owner_onehot(owner_n);
        hold_ack_n = (state_n == ST_HOLD);
    end

    // State, owner and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_INT;
            owner_q    <= OWN_CPU;
            grant_q    <= owner_onehot(OWN_CPU);
            hold_ack_q <= 1'b0;
        end else begin
            state_q    <= state_n;
            owner_q    <= owner_n;
            grant_q    <= grant_n;
            hold_ack_q <= hold_ack_n;
        end
    end

endmodule

// File: rtl/bus_owner_arbiter.sv
// Module: bus_owner_arbiter (top)
// Six-level fixed-priority bus arbiter with an external hold handshake.
// Assumes bus_cycle_end is a one-clock pulse on the final clock of the
// bus cycle run by the current internal owner.
module bus_owner_arbiter
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_lock_req,
    input  logic       cpu_req,
    input  logic       dma_req,
    input  logic       rfsh_urgent_req,
    input  logic       rfsh_bg_req,
    input  logic       bus_cycle_end,
    input  logic       ext_hold_req,
    output logic       ext_hold_ack,
    output logic [3:0] grant
);

    logic [N_LEVELS-1:0] lvl_req;
    logic [N_OWNERS-1:0] owner_req;
    logic                reclaim_req;
    owner_e              pick_all;
    owner_e              pick_int;
    logic                any_all;
    logic                any_int;

    arb_req_map u_map (
        .cpu_lock_req    (cpu_lock_req),
        .cpu_req         (cpu_req),
        .dma_req         (dma_req),
        .rfsh_urgent_req (rfsh_urgent_req),
        .rfsh_bg_req     (rfsh_bg_req),
        .ext_hold_req    (ext_hold_req),
        .lvl_req         (lvl_req),
        .owner_req       (owner_req),
        .reclaim_req     (reclaim_req)
    );

    arb_prio_pick #(.LEVELS(N_LEVELS), .INCLUDE_HOLD(1'b1)) u_pick_all (
        .lvl_req (lvl_req),
        .pick    (pick_all),
        .any_req (any_all)
    );

    arb_prio_pick #(.LEVELS(N_LEVELS), .INCLUDE_HOLD(1'b0)) u_pick_int (
        .lvl_req (lvl_req),
        .pick    (pick_int),
        .any_req (any_int)
    );

    arb_owner_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .pick_all      (pick_all),
        .pick_int      (pick_int),
        .owner_req     (owner_req),
        .reclaim_req   (reclaim_req),
        .ext_hold_req  (ext_hold_req),
        .bus_cycle_end (bus_cycle_end),
        .grant_q       (grant),
        .hold_ack_q    (ext_hold_ack)
    );

    // The "any" flags only matter to observers of the pick; keep them tied off.
    logic unused_any;
    assign unused_any = any_all ^ any_int;

endmodule

// File: rtl/arb_checker.sv
// Module: arb_checker
// Concurrent properties on the arbiter ports, bound into the top module.
module arb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_lock_req,
    input logic       cpu_req,
    input logic       dma_req,
    input logic       rfsh_urgent_req,
    input logic       rfsh_bg_req,
    input logic       bus_cycle_end,
    input logic       ext_hold_req,
    input logic       ext_hold_ack,
    input logic [3:0] grant
);

    a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r3_dma_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == 4'b0010 && dma_req && !bus_cycle_end) |=> $stable(grant));

    a_r3_cpu_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == 4'b0001 && cpu_req && !bus_cycle_end) |=> $stable(grant));

    a_r5_lock_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != 4'b0000 && !ext_hold_ack && bus_cycle_end && cpu_lock_req)
        |=> (grant == 4'b0001));

    a_r7_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_hold_ack) |-> ($past(ext_hold_req) && grant == 4'b1000));

    a_r8_reclaim: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_hold_ack && ext_hold_req && (cpu_lock_req || rfsh_urgent_req || dma_req))
        |=> (!ext_hold_ack && grant == 4'b0000));

    a_r9_bus_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == 4'b0000 && ext_hold_req) |=> (grant == 4'b0000));

    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_hold_ack && !ext_hold_req) |=> !ext_hold_ack);

    a_r11_park: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == 4'b0001 && !cpu_lock_req && !cpu_req && !dma_req &&
         !rfsh_urgent_req && !rfsh_bg_req && !ext_hold_req) |=> (grant == 4'b0001));

    a_r12_ack_matches_grant: assert property (@(posedge clk) disable iff (!rst_n)
        ext_hold_ack == grant[3]);

endmodule

bind bus_owner_arbiter arb_checker u_arb_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .cpu_lock_req    (cpu_lock_req),
    .cpu_req         (cpu_req),
    .dma_req         (dma_req),
    .rfsh_urgent_req (rfsh_urgent_req),
    .rfsh_bg_req     (rfsh_bg_req),
    .bus_cycle_end   (bus_cycle_end),
    .ext_hold_req    (ext_hold_req),
    .ext_hold_ack    (ext_hold_ack),
    .grant           (grant)
);

// File: tb/bus_owner_arbiter_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, compared each
// cycle against a cycle model written from the requirements.
module bus_owner_arbiter_test;

    localparam logic [3:0] G_CPU = 4'b0001;
    localparam logic [3:0] G_DMA = 4'b0010;
    localparam logic [3:0] G_RF  = 4'b0100;
    localparam logic [3:0] G_EXT = 4'b1000;
    localparam logic [3:0] G_NONE = 4'b0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_i = 0, cpu_i = 0, dma_i = 0, urg_i = 0, bg_i = 0, ce_i = 0, hold_i = 0;
    logic       ack_o;
    logic [3:0] grant_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    logic [3:0] m_grant = G_CPU;
    logic       m_ack   = 1'b0;
    string      m_tag   = "R1";

    always #4 clk = ~clk;

    bus_owner_arbiter uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cpu_lock_req    (lock_i),
        .cpu_req         (cpu_i),
        .dma_req         (dma_i),
        .rfsh_urgent_req (urg_i),
        .rfsh_bg_req     (bg_i),
        .bus_cycle_end   (ce_i),
        .ext_hold_req    (hold_i),
        .ext_hold_ack    (ack_o),
        .grant           (grant_o)
    );

    // Highest request in the full order (R4), processor when idle (R11).
    function automatic logic [3:0] full_winner();
        if (lock_i) return G_CPU;
        if (urg_i)  return G_RF;
        if (dma_i)  return G_DMA;
        if (hold_i) return G_EXT;
        if (cpu_i)  return G_CPU;
        if (bg_i)   return G_RF;
        return G_CPU;
    endfunction

    // Highest internal request, used when the external master leaves.
    function automatic logic [3:0] int_winner();
        if (lock_i) return G_CPU;
        if (urg_i)  return G_RF;
        if (dma_i)  return G_DMA;
        if (cpu_i)  return G_CPU;
        if (bg_i)   return G_RF;
        return G_CPU;
    endfunction

    // Advance the cycle model by one edge from the present inputs.
    task automatic model_edge();
        logic busy;
        if (!rst_n) begin
            m_grant = G_CPU; m_ack = 0; m_tag = "R1";
        end else if (m_grant == G_EXT) begin
            if (!hold_i) begin
                m_grant = int_winner(); m_ack = 0; m_tag = "R10";
            end else if (lock_i || urg_i || dma_i) begin
                m_grant = G_NONE; m_ack = 0; m_tag = "R8";
            end else begin
                m_tag = "R12";
            end
        end else if (m_grant == G_NONE) begin
            if (!hold_i) m_grant = int_winner();
            m_tag = "R9";
        end else begin
            busy = (m_grant == G_CPU) ? (cpu_i | lock_i) :
                   (m_grant == G_DMA) ? dma_i : (urg_i | bg_i);
            if (ce_i || !busy) begin
                m_grant = full_winner();
                m_ack   = (m_grant == G_EXT);
                m_tag   = (m_ack) ? "R7" : "R4";
            end else begin
                m_tag = "R3";
            end
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual {ack,grant}=%b expected %b", tag, act, exp);
        end
    endtask

    // One edge: update the model, then compare away from the edge.
    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        check({ack_o, grant_o} === {m_ack, m_grant}, m_tag, {ack_o, grant_o}, {m_ack, m_grant});
        check($countones(grant_o) <= 1, "R2", {ack_o, grant_o}, {m_ack, m_grant});
    endtask

    task automatic drive(input logic lk, cp, dm, ug, bgr, hd, ce);
        @(negedge clk);
        lock_i = lk; cpu_i = cp; dma_i = dm; urg_i = ug; bg_i = bgr; hold_i = hd; ce_i = ce;
        step();
    endtask

    task automatic expect_out(input logic [3:0] g, input logic a, input string tag);
        check({ack_o, grant_o} === {a, g}, tag, {ack_o, grant_o}, {a, g});
    endtask

    // Watchdog: a hang is one failed check and still reaches the summary.
    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4471);
        // R1: reset state
        repeat (3) step();
        expect_out(G_CPU, 0, "R1");
        @(negedge clk); rst_n = 1;
        step();
        expect_out(G_CPU, 0, "R1");

        // R6: background refresh alone is granted; R3 it then holds
        drive(0, 0, 0, 0, 1, 0, 1); expect_out(G_RF, 0, "R6");
        drive(0, 1, 1, 0, 1, 0, 0); expect_out(G_RF, 0, "R3");
        // R4: DMA outranks processor at the cycle end
        drive(0, 1, 1, 0, 1, 0, 1); expect_out(G_DMA, 0, "R4");
        // R6: processor beats background refresh
        drive(0, 1, 0, 0, 1, 0, 1); expect_out(G_CPU, 0, "R6");
        // R5: locked processor beats urgent refresh, DMA and hold
        drive(0, 0, 1, 0, 0, 0, 1); expect_out(G_DMA, 0, "R4");
        drive(1, 0, 1, 1, 0, 1, 1); expect_out(G_CPU, 0, "R5");
        // R4: urgent refresh beats DMA
        drive(0, 0, 1, 1, 0, 0, 1); expect_out(G_RF, 0, "R4");
        // R11: idle parks on processor
        drive(0, 0, 0, 0, 0, 0, 1); expect_out(G_CPU, 0, "R11");
        drive(0, 0, 0, 0, 0, 0, 0); expect_out(G_CPU, 0, "R11");
        // R7: hold wins over processor and background refresh
        drive(0, 1, 0, 0, 1, 1, 1); expect_out(G_EXT, 1, "R7");
        // R12: cycle end and low-rank requests ignored during hold
        drive(0, 1, 0, 0, 1, 1, 1); expect_out(G_EXT, 1, "R12");
        // R8: DMA reclaims the bus
        drive(0, 0, 1, 0, 0, 1, 0); expect_out(G_NONE, 0, "R8");
        // R9: bus wait while hold stays high, then DMA granted
        drive(0, 0, 1, 0, 0, 1, 0); expect_out(G_NONE, 0, "R9");
        drive(0, 0, 1, 0, 0, 0, 0); expect_out(G_DMA, 0, "R9");
        // R10: voluntary release goes to processor
        drive(0, 0, 0, 0, 0, 1, 1); expect_out(G_EXT, 1, "R7");
        drive(0, 0, 0, 0, 0, 0, 0); expect_out(G_CPU, 0, "R10");

        // Seeded random traffic against the model
        for (int cyc = 0; cyc < 6000; cyc++) begin
            logic h;
            h = hold_i;
            if (h) begin
                if (($urandom % (m_ack ? 6 : 3)) == 0) h = 0;
            end else if (($urandom % 5) == 0) begin
                h = 1;
            end
            drive(($urandom % 10) == 0, ($urandom % 2) == 0, ($urandom % 3) == 0,
                  ($urandom % 8) == 0, ($urandom % 3) == 0, h, ($urandom % 3) == 0);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule